// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block times the clock line of an I2C master. A programmable prescaler divides the functional clock into an internal time base. The generator then alternates between a low phase and a high phase. Each phase lasts a programmed field plus a fixed offset, counted in internal clock periods. The output is a drive enable for the open-drain SCL pad: when the enable is 1 the pad pulls SCL low, and when it is 0 the line is released. A one-cycle strobe marks each falling edge and each rising edge, so that the bit engine beside this block knows when to change or sample SDA.

Each timing configuration word holds two timing sets:

- the upper byte holds the high-speed value;
- the lower byte holds the fast or standard value.

With high-speed operation enabled, the first part of a transfer uses the lower bytes and the prescaled time base; this is the part that carries the master code. The bit engine then raises a switch strobe. From the next low phase on, the generator uses the upper bytes and counts directly on the functional clock. Between transfers SCL stays released.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and for as long as `run` is 0, `scl_drive_low`, `tick_fall`, `tick_rise` and `hs_active` are all 0.
- R2: When `run` is sampled 1 while the generator is idle, then in the next cycle `scl_drive_low` is 1 and `tick_fall` is 1 for that single cycle.
- R3: Standard timing (`hs_active`=0): a low phase lasts (`scl_lo_cfg[7:0]` + 7) × (`presc` + 1) functional clock cycles.
- R4: Standard timing: a high phase lasts (`scl_hi_cfg[7:0]` + 5) × (`presc` + 1) functional clock cycles.
- R5: `tick_rise` pulses for one cycle in the first cycle of every high phase, and `tick_fall` pulses for one cycle in the first cycle of every low phase. The two never pulse in the same cycle.
- R6: If `hs_switch` is pulsed while `hs_mode` is 1, then `hs_active` becomes 1 at the start of the next low phase, never in the middle of a phase. From then on:
  - a low phase lasts (`scl_lo_cfg[15:8]` + 7) cycles;
  - a high phase lasts (`scl_hi_cfg[15:8]` + 5) cycles;
  - `presc` is not applied.
- R7: An `hs_switch` pulse sampled in the last cycle of a high phase takes effect in the low phase that starts at the very next edge.
- R8: An `hs_switch` pulse while `hs_mode` is 0 is ignored: `hs_active` stays 0 and the following phases keep standard timing.
- R9: `run` sampled 0 returns the generator to idle in the next cycle, with SCL released and `hs_active` at 0. A pending switch is discarded, so the next transfer starts with standard timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | 1 while a transfer is in progress; 0 holds SCL released |
| hs_mode | input | 1 | Enables high-speed operation (allows the switch) |
| hs_switch | input | 1 | One-cycle strobe: change to the high-speed timing set |
| presc | input | PSC_W | Prescaler; the internal clock is clk / (presc + 1) |
| scl_lo_cfg | input | 2*FIELD_W | Low-time word: [15:8] high-speed value, [7:0] standard value |
| scl_hi_cfg | input | 2*FIELD_W | High-time word: [15:8] high-speed value, [7:0] standard value |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| tick_fall | output | 1 | One-cycle pulse when SCL falls |
| tick_rise | output | 1 | One-cycle pulse when SCL rises |
| hs_active | output | 1 | 1 while the high-speed timing set is in use |

## Verification
Two events can land in the same cycle: the high-to-low phase boundary and a switch strobe. The bench measures the high phase after a rising tick. It then places `hs_switch` exactly in the last cycle of that phase. It expects a falling tick in the next cycle with `hs_active` already set, and a low phase of the high-speed length. A strobe placed earlier in the high phase must leave that phase's length untouched. A strobe followed at once by `run` dropping must leave the next transfer on standard timing.

// File: rtl/scl_timing_pkg.sv
// Shared types and constants for the SCL timing generator.
package scl_timing_pkg;

    // Bus phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Fixed offsets added to the programmed low and high fields.
    localparam int LO_OFS = 7;
    localparam int HI_OFS = 5;

endpackage

// File: rtl/scl_field_sel.sv
// Picks the timing field and divider for the current phase.
// Assumes the configuration words are stable during a transfer.
// Output len_m1 is the phase length in internal ticks, minus one.
module scl_field_sel
    import scl_timing_pkg::*;
#(
    parameter int PSC_W   = 8,
    parameter int FIELD_W = 8,
    localparam int REG_W  = 2 * FIELD_W,
    localparam int CNT_W  = FIELD_W + 1
) (
    input  logic               hs_active,
    input  logic               phase_low,
    input  logic [PSC_W-1:0]   presc,
    input  logic [REG_W-1:0]   lo_cfg,
    input  logic [REG_W-1:0]   hi_cfg,
    output logic [PSC_W-1:0]   div_limit,
    output logic [CNT_W-1:0]   len_m1
);

    logic [FIELD_W-1:0] lo_field;
    logic [FIELD_W-1:0] hi_field;

    // Select the upper (high-speed) or lower (standard) byte of each word.
    always_comb begin
        lo_field = hs_active ? lo_cfg[REG_W-1:FIELD_W] : lo_cfg[FIELD_W-1:0];
        hi_field = hs_active ? hi_cfg[REG_W-1:FIELD_W] : hi_cfg[FIELD_W-1:0];
    end

    // In the high-speed phase the functional clock is used undivided.
    always_comb div_limit = hs_active ? '0 : presc;

    // Phase length in internal ticks minus one, offsets included.
    always_comb begin
        if (phase_low)
            len_m1 = {1'b0, lo_field} + CNT_W'(LO_OFS - 1);
        else
            len_m1 = {1'b0, hi_field} + CNT_W'(HI_OFS - 1);
    end

endmodule

// File: rtl/scl_prescaler.sv
// Produces a one-cycle internal tick every (limit + 1) functional cycles.
// A clear realigns the divider to the start of a phase.
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             clr,
    input  logic [PSC_W-1:0] limit,
    output logic             itick
);

    logic [PSC_W-1:0] cnt;

    // The tick fires on the last functional cycle of each internal period.
    always_comb itick = active && (cnt == limit);

    // Divider counter: cleared at a phase start, wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (itick)
            cnt <= '0;
        else if (active)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/scl_phase_ctrl.sv
// Low/high phase sequencer with the high-speed switch logic.
// Assumes the phase lengths it is given stay stable within a phase.
// A switch request is applied only at a high-to-low boundary.
module scl_phase_ctrl
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hs_mode,
    input  logic             hs_switch,
    input  logic             itick,
    input  logic [CNT_W-1:0] len_m1,
    output logic             phase_start,
    output logic             running,
    output logic             phase_low,
    output logic             scl_drive_low,
    output logic             tick_fall,
    output logic             tick_rise,
    output logic             hs_active
);

    scl_phase_e       phase;
    logic [CNT_W-1:0] tcnt;
    logic             pending;
    logic             end_ph;
    logic             to_low;
    logic             to_high;
    logic             sw_req;

    // Decode the current phase for the field selector and the pad.
    always_comb begin
        running       = (phase != PH_IDLE);
        phase_low     = (phase == PH_LOW);
        scl_drive_low = (phase == PH_LOW);
    end

    // Phase boundary decode and switch request.
    always_comb begin
        end_ph      = running && itick && (tcnt == len_m1);
        to_low      = run && ((phase == PH_IDLE) ||
                              ((phase == PH_HIGH) && end_ph));
        to_high     = run && (phase == PH_LOW) && end_ph;
        phase_start = to_low || to_high;
        sw_req      = hs_mode && hs_switch;
    end

    // Phase state, tick counter, edge strobes and high-speed switch.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase     <= PH_IDLE;
            tcnt      <= '0;
            tick_fall <= 1'b0;
            tick_rise <= 1'b0;
            hs_active <= 1'b0;
            pending   <= 1'b0;
        end else begin
            tick_fall <= to_low;
            tick_rise <= to_high;
            if (phase_start)
                tcnt <= '0;
            else if (itick)
                tcnt <= tcnt + 1'b1;
            if (to_low)
                phase <= PH_LOW;
            else if (to_high)
                phase <= PH_HIGH;
            if (to_low && (phase == PH_HIGH) && (pending || sw_req)) begin
                hs_active <= 1'b1;
                pending   <= 1'b0;
            end else if (sw_req) begin
                pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
// Top level of the SCL timing generator.
// Wires together the field selector, the prescaler and the phase sequencer.
// Assumes the configuration inputs do not change during a transfer.
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int PSC_W   = 8,
    parameter int FIELD_W = 8,
    localparam int REG_W  = 2 * FIELD_W,
    localparam int CNT_W  = FIELD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hs_mode,
    input  logic             hs_switch,
    input  logic [PSC_W-1:0] presc,
    input  logic [REG_W-1:0] scl_lo_cfg,
    input  logic [REG_W-1:0] scl_hi_cfg,
    output logic             scl_drive_low,
    output logic             tick_fall,
    output logic             tick_rise,
    output logic             hs_active
);

    logic             itick;
    logic             phase_start;
    logic             running;
    logic             phase_low;
    logic [PSC_W-1:0] div_limit;
    logic [CNT_W-1:0] len_m1;
    logic             psc_clr;

    // The divider restarts at every phase start and is held while idle.
    always_comb psc_clr = phase_start || !running;

    scl_field_sel #(
        .PSC_W   (PSC_W),
        .FIELD_W (FIELD_W)
    ) u_sel (
        .hs_active (hs_active),
        .phase_low (phase_low),
        .presc     (presc),
        .lo_cfg    (scl_lo_cfg),
        .hi_cfg    (scl_hi_cfg),
        .div_limit (div_limit),
        .len_m1    (len_m1)
    );

    scl_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (running),
        .clr    (psc_clr),
        .limit  (div_limit),
        .itick  (itick)
    );

    scl_phase_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .hs_mode       (hs_mode),
        .hs_switch     (hs_switch),
        .itick         (itick),
        .len_m1        (len_m1),
        .phase_start   (phase_start),
        .running       (running),
        .phase_low     (phase_low),
        .scl_drive_low (scl_drive_low),
        .tick_fall     (tick_fall),
        .tick_rise     (tick_rise),
        .hs_active     (hs_active)
    );

endmodule

// File: rtl/scl_timing_chk.sv
// Protocol checker for scl_timing_gen, attached to it by bind.
// Watches only the top-level ports.
module scl_timing_chk #(
    parameter int PSC_W   = 8,
    parameter int FIELD_W = 8,
    localparam int REG_W  = 2 * FIELD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [PSC_W-1:0] presc,
    input logic [REG_W-1:0] scl_lo_cfg,
    input logic             scl_drive_low,
    input logic             tick_fall,
    input logic             tick_rise,
    input logic             hs_active
);

    logic run_q;
    int   lcnt;
    int   exp_low;

    // Remember the previous run level to detect a start from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run;
    end

    // Count cycles since the last falling tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         lcnt <= 0;
        else if (tick_fall) lcnt <= 1;
        else                lcnt <= lcnt + 1;
    end

    // Expected low-phase length for the timing set in use.
    always_comb begin
        if (hs_active)
            exp_low = int'(scl_lo_cfg[REG_W-1:FIELD_W]) + 7;
        else
            exp_low = (int'(scl_lo_cfg[FIELD_W-1:0]) + 7) * (int'(presc) + 1);
    end

    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!scl_drive_low && !tick_fall && !tick_rise && !hs_active));

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !run_q) |=> (scl_drive_low && tick_fall));

    p_ticks_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_fall && tick_rise));

    p_fall_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_fall |-> (scl_drive_low && !$past(scl_drive_low)));

    p_rise_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |-> (!scl_drive_low && $past(scl_drive_low)));

    p_hs_at_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_active) |-> tick_fall);

    p_low_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_rise && run) |-> (lcnt == exp_low));

endmodule

bind scl_timing_gen scl_timing_chk #(
    .PSC_W   (PSC_W),
    .FIELD_W (FIELD_W)
) u_scl_timing_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .presc         (presc),
    .scl_lo_cfg    (scl_lo_cfg),
    .scl_drive_low (scl_drive_low),
    .tick_fall     (tick_fall),
    .tick_rise     (tick_rise),
    .hs_active     (hs_active)
);

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        hs_mode = 1'b0;
    logic        hs_switch = 1'b0;
    logic [7:0]  presc = '0;
    logic [15:0] scl_lo_cfg = '0;
    logic [15:0] scl_hi_cfg = '0;
    logic        scl_drive_low;
    logic        tick_fall;
    logic        tick_rise;
    logic        hs_active;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    scl_timing_gen u_scl_timing_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .hs_mode       (hs_mode),
        .hs_switch     (hs_switch),
        .presc         (presc),
        .scl_lo_cfg    (scl_lo_cfg),
        .scl_hi_cfg    (scl_hi_cfg),
        .scl_drive_low (scl_drive_low),
        .tick_fall     (tick_fall),
        .tick_rise     (tick_rise),
        .hs_active     (hs_active)
    );

    // Expected phase length in functional cycles.
    function automatic int exp_len(input int field, input int ofs, input int div);
        return (field + ofs) * div;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count cycles from the current negedge to the next wanted tick.
    task automatic measure(input bit want_rise, input bit pulse, output int n, output bit other);
        n = 0;
        other = 1'b0;
        if (pulse) hs_switch = 1'b1;
        forever begin
            @(negedge clk);
            hs_switch = 1'b0;
            n++;
            if (want_rise ? tick_rise : tick_fall) break;
            if (want_rise ? tick_fall : tick_rise) other = 1'b1;
            if (n > 5000) break;
        end
    endtask

    task automatic start_xfer();
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        chk(scl_drive_low && tick_fall, "R2 start low+fall", {scl_drive_low, tick_fall}, 3);
    endtask

    task automatic stop_xfer();
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low && !hs_active && !tick_fall && !tick_rise, "R9 stop idle",
            {scl_drive_low, hs_active, tick_fall, tick_rise}, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        bit oth;
        int ok_idle;
        int div, lo, hi;
        void'($urandom(32'h5c1_7e57));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset with run low.
        ok_idle = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (scl_drive_low || tick_fall || tick_rise || hs_active) ok_idle = 0;
        end
        chk(ok_idle == 1, "R1 idle released", ok_idle, 1);

        // Directed corner: zero prescaler and zero fields.
        presc = 8'd0; scl_lo_cfg = 16'h0000; scl_hi_cfg = 16'h0000;
        start_xfer();
        measure(1'b1, 1'b0, n, oth);
        chk(n == 7, "R3 min low", n, 7);
        chk(!oth, "R5 no fall in low", oth, 0);
        measure(1'b0, 1'b0, n, oth);
        chk(n == 5, "R4 min high", n, 5);
        chk(!oth, "R5 no rise in high", oth, 0);
        chk(tick_fall && !tick_rise, "R5 fall alone", {tick_fall, tick_rise}, 2);
        stop_xfer();

        // Random standard timing.
        for (int k = 0; k < 6; k++) begin
            presc = 8'($urandom_range(0, 3));
            scl_lo_cfg = {8'($urandom_range(0, 255)), 8'($urandom_range(0, 20))};
            scl_hi_cfg = {8'($urandom_range(0, 255)), 8'($urandom_range(0, 20))};
            div = int'(presc) + 1;
            lo = int'(scl_lo_cfg[7:0]);
            hi = int'(scl_hi_cfg[7:0]);
            start_xfer();
            for (int p = 0; p < 2; p++) begin
                measure(1'b1, 1'b0, n, oth);
                chk(n == exp_len(lo, 7, div), "R3 low length", n, exp_len(lo, 7, div));
                measure(1'b0, 1'b0, n, oth);
                chk(n == exp_len(hi, 5, div), "R4 high length", n, exp_len(hi, 5, div));
            end
            stop_xfer();
        end

        // R6: switch during a high phase applies at the next low.
        hs_mode = 1'b1; presc = 8'd3; scl_lo_cfg = 16'h020A; scl_hi_cfg = 16'h0106;
        start_xfer();
        measure(1'b1, 1'b0, n, oth);
        chk(n == 68, "R6 first low standard", n, 68);
        measure(1'b0, 1'b1, n, oth);
        chk(n == 44, "R6 high unchanged by strobe", n, 44);
        chk(hs_active == 1'b1, "R6 hs at fall", hs_active, 1);
        measure(1'b1, 1'b0, n, oth);
        chk(n == 9, "R6 hs low", n, 9);
        measure(1'b0, 1'b0, n, oth);
        chk(n == 6, "R6 hs high", n, 6);
        measure(1'b1, 1'b0, n, oth);
        chk(n == 9, "R6 hs low again", n, 9);
        stop_xfer();

        // R7: strobe in the last cycle of a high phase.
        presc = 8'd1; scl_lo_cfg = 16'h0304; scl_hi_cfg = 16'h0102;
        start_xfer();
        measure(1'b1, 1'b0, n, oth);
        chk(n == 22, "R7 first low", n, 22);
        repeat (13) @(negedge clk);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        chk(tick_fall && hs_active, "R7 same-edge switch", {tick_fall, hs_active}, 3);
        measure(1'b1, 1'b0, n, oth);
        chk(n == 10, "R7 hs low", n, 10);
        stop_xfer();

        // R8: strobe ignored without high-speed mode.
        hs_mode = 1'b0;
        start_xfer();
        measure(1'b1, 1'b0, n, oth);
        measure(1'b0, 1'b1, n, oth);
        chk(n == 14, "R8 high", n, 14);
        chk(hs_active == 1'b0, "R8 hs stays off", hs_active, 0);
        measure(1'b1, 1'b0, n, oth);
        chk(n == 22, "R8 low standard", n, 22);
        stop_xfer();

        // R9: pending switch discarded by a stop.
        hs_mode = 1'b1;
        start_xfer();
        measure(1'b1, 1'b0, n, oth);
        @(negedge clk);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        run = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low && !hs_active, "R9 idle after stop", {scl_drive_low, hs_active}, 0);
        start_xfer();
        measure(1'b1, 1'b0, n, oth);
        chk(n == 22, "R9 restart standard low", n, 22);
        measure(1'b0, 1'b0, n, oth);
        chk(n == 14, "R9 restart standard high", n, 14);
        chk(hs_active == 1'b0, "R9 pending dropped", hs_active, 0);
        stop_xfer();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule